// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block sits beside a 32-bit target on a parallel PCI-style bus. It handles parity in both directions. On every clock it computes the even-parity bit over the multiplexed address/data lines and the active-low command/byte-enable lines. When the target drove read data in a clock, that bit goes out on the PAR line during the following clock.

When the target state machine marks an address phase or a completed write data phase, the block waits one clock and compares the incoming PAR against the bit it computed. A mismatch in a data phase is a data parity error. It is reported on the active-low data-error line two clocks after the phase. A mismatch in an address phase, or in a data phase of a special cycle, is reported instead as a one-clock pulse on the active-low system-error line.

Each reporting line has its own enable input. The block also keeps two sticky status bits, which software clears by writing a one. All outputs come from registers, and every tri-state pin has its own output-enable output, so the pad ring does the tri-stating.

Top module: `pci_par_unit`

## Requirements
- R1: `par_o` in clock N+1 equals the bit that makes the ones in `ad_i`, `cbe_n_i` and that bit, taken from clock N, an even count.
- R2: `par_oe_o` in clock N+1 equals `rd_oe_i` from clock N.
- R3: When `addr_phase_i` is high in clock N and `par_i` in clock N+1 breaks even parity, with `serr_en_i` high in N+1, `serr_n_o` is low and `serr_oe_o` is high in clock N+2 only. `perr_oe_o` stays low.
- R4: When `wr_data_i` is high (and `addr_phase_i` low) in clock N and `par_i` in N+1 breaks even parity, with `special_i` low in N and `perr_en_i` high in N+1, `perr_n_o` is low with `perr_oe_o` high in clock N+2.
- R5: After its last low clock, `perr_n_o` is driven high with `perr_oe_o` high for two clocks, and `perr_oe_o` then falls.
- R6: A data parity error in a phase that had `special_i` high is reported as in R3 on the system-error pins, not on the data-error pins.
- R7: No check is made in a clock where `par_oe_o` is high. A bad `par_i` in that clock reports nothing and sets no status.
- R8: When `perr_en_i` or `serr_en_i` is low in the checking clock, the matching pin is not driven for that error.
- R9: `sts_o[0]` is set by any detected parity error, whatever the enables, and `sts_o[1]` is set when `serr_n_o` is driven low. Both bits appear in the same clock as the report and stay set until a one is written to the same bit of `sts_clr_i`; a new set beats a clear.
- R10: In reset and after it, both output enables are low, `perr_n_o`/`serr_n_o` are high, `par_o` is 0 and `sts_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | AD_W | Address/data lines as seen on the bus |
| cbe_n_i | input | BE_W | Active-low command/byte-enable lines |
| par_i | input | 1 | Parity line as seen on the bus |
| addr_phase_i | input | 1 | Address phase valid in this clock |
| wr_data_i | input | 1 | Write data phase completes in this clock |
| rd_oe_i | input | 1 | Target drives read data on `ad_i` this clock |
| special_i | input | 1 | Current transaction is a special cycle |
| perr_en_i | input | 1 | Enable for data-error reporting |
| serr_en_i | input | 1 | Enable for system-error reporting |
| sts_clr_i | input | 2 | Write-one-to-clear for the status bits |
| par_o | output | 1 | Generated parity |
| par_oe_o | output | 1 | Output enable for `par_o` |
| perr_n_o | output | 1 | Active-low data parity error |
| perr_oe_o | output | 1 | Output enable for `perr_n_o` |
| serr_n_o | output | 1 | Active-low system error |
| serr_oe_o | output | 1 | Output enable for `serr_n_o` |
| sts_o | output | 2 | Sticky status: bit 0 parity error seen, bit 1 system error signalled |

## Verification
Directed phases come first. They are an address phase with a bad parity bit, a write phase with a bad parity bit, and the same write marked as a special cycle. The last one has to move the report from the data-error pins to the system-error pins. A bad parity bit lands on a clock where the block drives PAR itself, and must be ignored. Both enables are turned off while status must still record the error. Random phases then mix strobes, parity bits, enables and clears, including back-to-back errors that extend the low time of the data-error line. A bench model compares every output on every clock, so a wrong latency, a missing high tail or a mixed-up status bit shows up.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  // status bit positions
  localparam int STS_W   = 2;
  localparam int STS_DPE = 0;  // parity error seen
  localparam int STS_SSE = 1;  // system error signalled
  // clocks the data-error pin is held high before release
  localparam int PERR_TAIL = 2;

  function automatic logic even_bit(input logic [63:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            rd_oe_i,
  output logic            par_o,
  output logic            par_oe_o
);
  localparam int TOT_W = AD_W + BE_W;

  logic [63:0] vec;
  always_comb begin
    vec = '0;
    vec[TOT_W-1:0] = {cbe_n_i, ad_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= pci_par_pkg::even_bit(vec);
      par_oe_o <= rd_oe_i;
    end
  end
endmodule

// File: rtl/pci_par_check.sv
module pci_par_check #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            par_i,
  input  logic            addr_phase_i,
  input  logic            wr_data_i,
  input  logic            special_i,
  input  logic            own_drive_i,
  output logic            addr_err_o,
  output logic            data_err_o,
  output logic            special_o
);
  localparam int TOT_W = AD_W + BE_W;

  logic [63:0] vec;
  logic        pend_a, pend_d, pend_s, pend_p;
  logic        mism, active;

  always_comb begin
    vec = '0;
    vec[TOT_W-1:0] = {cbe_n_i, ad_i};
  end

  // capture the phase, compare with PAR one clock later
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a <= 1'b0;
      pend_d <= 1'b0;
      pend_s <= 1'b0;
      pend_p <= 1'b0;
    end else begin
      pend_a <= addr_phase_i;
      pend_d <= wr_data_i & ~addr_phase_i;
      pend_s <= special_i;
      pend_p <= pci_par_pkg::even_bit(vec);
    end
  end

  assign mism       = par_i ^ pend_p;
  assign active     = mism & ~own_drive_i;
  assign addr_err_o = pend_a & active;
  assign data_err_o = pend_d & active;
  assign special_o  = pend_s;
endmodule

// File: rtl/pci_err_drive.sv
module pci_err_drive #(
  parameter int TAIL = pci_par_pkg::PERR_TAIL
) (
  input  logic clk,
  input  logic rst,
  input  logic perr_req_i,
  input  logic serr_req_i,
  output logic perr_n_o,
  output logic perr_oe_o,
  output logic serr_n_o,
  output logic serr_oe_o
);
  localparam int CW = $clog2(TAIL + 1);

  logic [CW-1:0] tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_n_o  <= 1'b1;
      perr_oe_o <= 1'b0;
      tail_q    <= '0;
    end else if (perr_req_i) begin
      perr_n_o  <= 1'b0;
      perr_oe_o <= 1'b1;
      tail_q    <= CW'(TAIL);
    end else if (tail_q != '0) begin
      perr_n_o  <= 1'b1;
      perr_oe_o <= 1'b1;
      tail_q    <= tail_q - 1'b1;
    end else begin
      perr_n_o  <= 1'b1;
      perr_oe_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      serr_n_o  <= 1'b1;
      serr_oe_o <= 1'b0;
    end else begin
      serr_n_o  <= ~serr_req_i;
      serr_oe_o <= serr_req_i;
    end
  end
endmodule

// File: rtl/pci_sts_bits.sv
module pci_sts_bits #(
  parameter int W = pci_par_pkg::STS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           sts_o[i] <= 1'b0;
      else if (set_i[i]) sts_o[i] <= 1'b1;
      else if (clr_i[i]) sts_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [BE_W-1:0]  cbe_n_i,
  input  logic             par_i,
  input  logic             addr_phase_i,
  input  logic             wr_data_i,
  input  logic             rd_oe_i,
  input  logic             special_i,
  input  logic             perr_en_i,
  input  logic             serr_en_i,
  input  logic [STS_W-1:0] sts_clr_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_n_o,
  output logic             perr_oe_o,
  output logic             serr_n_o,
  output logic             serr_oe_o,
  output logic [STS_W-1:0] sts_o
);
  logic addr_err, data_err, spec;
  logic perr_req, serr_req;
  logic [STS_W-1:0] sts_set;

  pci_par_gen #(.AD_W(AD_W), .BE_W(BE_W)) gen_i (
    .clk(clk), .rst(rst), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .rd_oe_i(rd_oe_i), .par_o(par_o), .par_oe_o(par_oe_o)
  );

  pci_par_check #(.AD_W(AD_W), .BE_W(BE_W)) chk_i (
    .clk(clk), .rst(rst), .ad_i(ad_i), .cbe_n_i(cbe_n_i), .par_i(par_i),
    .addr_phase_i(addr_phase_i), .wr_data_i(wr_data_i), .special_i(special_i),
    .own_drive_i(par_oe_o), .addr_err_o(addr_err), .data_err_o(data_err),
    .special_o(spec)
  );

  // special-cycle data errors move to the system-error pin
  assign perr_req = data_err & ~spec & perr_en_i;
  assign serr_req = (addr_err | (data_err & spec)) & serr_en_i;

  pci_err_drive #(.TAIL(PERR_TAIL)) drv_i (
    .clk(clk), .rst(rst), .perr_req_i(perr_req), .serr_req_i(serr_req),
    .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o),
    .serr_n_o(serr_n_o), .serr_oe_o(serr_oe_o)
  );

  always_comb begin
    sts_set          = '0;
    sts_set[STS_DPE] = addr_err | data_err;
    sts_set[STS_SSE] = serr_req;
  end

  pci_sts_bits #(.W(STS_W)) sts_i (
    .clk(clk), .rst(rst), .set_i(sts_set), .clr_i(sts_clr_i), .sts_o(sts_o)
  );
endmodule

// File: rtl/pci_par_unit_chk.sv
module pci_par_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_oe_i,
  input logic       perr_en_i,
  input logic       serr_en_i,
  input logic       par_oe_o,
  input logic       perr_n_o,
  input logic       perr_oe_o,
  input logic       serr_n_o,
  input logic       serr_oe_o,
  input logic [1:0] sts_o
);
  a_r2_par_oe_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> par_oe_o == $past(rd_oe_i));

  a_r3_serr_driven: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> serr_oe_o);

  a_r4_perr_driven: assert property (@(posedge clk) disable iff (rst)
    !perr_n_o |-> perr_oe_o);

  a_r5_perr_high_tail: assert property (@(posedge clk) disable iff (rst)
    $fell(perr_oe_o) |-> ($past(perr_n_o, 1) && $past(perr_n_o, 2)
                          && $past(perr_oe_o, 2)));

  a_r8_perr_needs_en: assert property (@(posedge clk) disable iff (rst)
    $fell(perr_n_o) |-> $past(perr_en_i));

  a_r8_serr_needs_en: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> $past(serr_en_i));

  a_r9_sse_with_serr: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_o[1]) |-> !serr_n_o);

  a_r10_serr_idle_high: assert property (@(posedge clk) disable iff (rst)
    !serr_oe_o |-> serr_n_o);
endmodule

bind pci_par_unit pci_par_unit_chk chk_bind_i (
  .clk(clk), .rst(rst), .rd_oe_i(rd_oe_i), .perr_en_i(perr_en_i),
  .serr_en_i(serr_en_i), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o),
  .perr_oe_o(perr_oe_o), .serr_n_o(serr_n_o), .serr_oe_o(serr_oe_o),
  .sts_o(sts_o)
);

// File: tb/pci_par_unit_tb_top.sv
`timescale 1ns/1ps
module pci_par_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic par = 1'b0, addr = 1'b0, wr = 1'b0, rd = 1'b0, spec = 1'b0;
  logic pen = 1'b1, sen = 1'b1;
  logic [1:0] clr = '0;
  logic par_o, par_oe, perr_n, perr_oe, serr_n, serr_oe;
  logic [1:0] sts;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_par_unit dut_i (
    .clk(clk), .rst(rst), .ad_i(ad), .cbe_n_i(cbe), .par_i(par),
    .addr_phase_i(addr), .wr_data_i(wr), .rd_oe_i(rd), .special_i(spec),
    .perr_en_i(pen), .serr_en_i(sen), .sts_clr_i(clr),
    .par_o(par_o), .par_oe_o(par_oe), .perr_n_o(perr_n), .perr_oe_o(perr_oe),
    .serr_n_o(serr_n), .serr_oe_o(serr_oe), .sts_o(sts)
  );

  function automatic logic epar(input logic [31:0] a, input logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i]);
    for (int i = 0; i < 4; i++) n += int'(c[i]);
    return (n % 2) == 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  logic m_par, m_paroe, m_pa, m_pd, m_ps, m_pp;
  logic m_perr, m_perroe, m_serr, m_serroe;
  int   m_tail;
  logic [1:0] m_sts;

  always @(posedge clk) begin
    logic bad, aerr, derr, preq, sreq;
    if (rst) begin
      m_par = 0; m_paroe = 0; m_pa = 0; m_pd = 0; m_ps = 0; m_pp = 0;
      m_perr = 1; m_perroe = 0; m_serr = 1; m_serroe = 0; m_tail = 0; m_sts = 0;
    end else begin
      bad  = (par != m_pp) && !m_paroe;
      aerr = m_pa && bad;
      derr = m_pd && bad;
      preq = derr && !m_ps && pen;
      sreq = (aerr || (derr && m_ps)) && sen;
      if (preq) begin m_perr = 0; m_perroe = 1; m_tail = 2; end
      else if (m_tail > 0) begin m_perr = 1; m_perroe = 1; m_tail--; end
      else begin m_perr = 1; m_perroe = 0; end
      m_serr = !sreq; m_serroe = sreq;
      for (int b = 0; b < 2; b++) begin
        logic s;
        s = (b == 0) ? (aerr || derr) : sreq;
        if (s) m_sts[b] = 1'b1;
        else if (clr[b]) m_sts[b] = 1'b0;
      end
      m_pa = addr; m_pd = wr && !addr; m_ps = spec; m_pp = epar(ad, cbe);
      m_par = epar(ad, cbe); m_paroe = rd;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(par_o == m_par, "R1 par_o", par_o, m_par);
      check(par_oe == m_paroe, "R2 par_oe_o", par_oe, m_paroe);
      check(perr_n == m_perr && perr_oe == m_perroe, "R4/R5 perr pins",
            {perr_oe, perr_n}, {m_perroe, m_perr});
      check(serr_n == m_serr && serr_oe == m_serroe, "R3/R6 serr pins",
            {serr_oe, serr_n}, {m_serroe, m_serr});
      check(sts == m_sts, "R9 sts_o", sts, m_sts);
    end
  end

  task automatic drive(input logic a_ph, input logic w_ph, input logic r_oe,
                       input logic sp, input logic [31:0] d, input logic [3:0] c,
                       input logic p);
    @(negedge clk);
    addr = a_ph; wr = w_ph; rd = r_oe; spec = sp; ad = d; cbe = c; par = p;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, '0, '0, 0);
    clr = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 2'b11;
    idle();
  endtask

  initial begin
    logic p;
    repeat (3) @(negedge clk);
    // R10 reset values
    check(!par_oe && !perr_oe && !serr_oe && perr_n && serr_n && !par_o && sts == 0,
          "R10 reset state", {par_oe, perr_oe, serr_oe, sts}, 0);
    @(negedge clk); rst = 1'b0;
    idle();
    check(!par_oe && !perr_oe && !serr_oe && sts == 0, "R10 after reset", sts, 0);

    // R3 address parity error
    p = epar(32'hDEAD_BEEF, 4'h6);
    drive(1, 0, 0, 0, 32'hDEAD_BEEF, 4'h6, 0);
    drive(0, 0, 0, 0, '0, '0, !p);
    idle();
    check(!serr_n && serr_oe && !perr_oe, "R3 serr low two clocks after address",
          {serr_oe, serr_n}, 2);
    check(sts == 2'b11, "R9 both status bits set", sts, 3);
    idle();
    check(!serr_oe && serr_n, "R3 serr one clock only", serr_oe, 0);
    check(sts == 2'b11, "R9 status sticky", sts, 3);
    clear_all();
    check(sts == 2'b00, "R9 write-one clears", sts, 0);

    // R4 / R5 write data error
    p = epar(32'h0123_4567, 4'h0);
    drive(0, 1, 0, 0, 32'h0123_4567, 4'h0, 0);
    drive(0, 0, 0, 0, '0, '0, !p);
    idle();
    check(!perr_n && perr_oe && !serr_oe, "R4 perr low two clocks after write",
          {perr_oe, perr_n}, 2);
    idle();
    check(perr_n && perr_oe, "R5 perr high tail 1", {perr_oe, perr_n}, 3);
    idle();
    check(perr_n && perr_oe, "R5 perr high tail 2", {perr_oe, perr_n}, 3);
    idle();
    check(!perr_oe, "R5 perr released", perr_oe, 0);
    clear_all();

    // R6 special cycle data error goes to serr
    p = epar(32'hA5A5_0F0F, 4'h1);
    drive(0, 1, 0, 1, 32'hA5A5_0F0F, 4'h1, 0);
    drive(0, 0, 0, 0, '0, '0, !p);
    idle();
    check(!serr_n && serr_oe && !perr_oe, "R6 special error on serr",
          {perr_oe, serr_oe, serr_n}, 2);
    clear_all();

    // R7 no check while block drives PAR
    p = epar(32'h5555_AAAA, 4'hF);
    drive(0, 1, 1, 0, 32'h5555_AAAA, 4'hF, 0);
    drive(0, 0, 0, 0, '0, '0, !p);
    idle();
    check(!perr_oe && !serr_oe && sts == 0, "R7 own PAR clock not checked",
          {perr_oe, serr_oe, sts}, 0);

    // R1 / R2 read parity
    drive(0, 0, 1, 0, 32'h8000_0001, 4'h8, 0);
    idle();
    check(par_oe && par_o == epar(32'h8000_0001, 4'h8), "R1 R2 read parity",
          {par_oe, par_o}, {1'b1, epar(32'h8000_0001, 4'h8)});
    idle();
    check(!par_oe, "R2 par_oe drops", par_oe, 0);

    // R8 enables off: nothing driven, status still records
    pen = 0; sen = 0;
    p = epar(32'h0, 4'h3);
    drive(1, 0, 0, 0, 32'h0, 4'h3, 0);
    drive(0, 1, 0, 0, 32'h0, 4'h3, !p);
    drive(0, 0, 0, 0, '0, '0, !p);
    check(!perr_oe && !serr_oe && sts == 2'b01, "R8 addr error, enables off",
          {perr_oe, serr_oe, sts}, 1);
    idle();
    check(!perr_oe && !serr_oe && sts == 2'b01, "R8 data error, enables off",
          {perr_oe, serr_oe, sts}, 1);
    pen = 1; sen = 1;
    clear_all();

    // random phases
    void'($urandom(32'd1553));
    for (int k = 0; k < 4000; k++) begin
      logic a_ph, w_ph;
      a_ph = ($urandom % 5) == 0;
      w_ph = ($urandom % 3) == 0;
      drive(a_ph, w_ph, ($urandom % 4) == 0, ($urandom % 6) == 0,
            $urandom, 4'($urandom), 1'($urandom));
      pen = ($urandom % 8) != 0;
      sen = ($urandom % 8) != 0;
      clr = ($urandom % 10 == 0) ? 2'($urandom) : 2'b00;
    end
    idle();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected<=100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule